// File: doc/BRIEF.md
# Event Timer Global Register Block

This block holds the shared registers of a multi-channel event timer: a free-running main counter, a read-only capability word, a two-bit configuration register and a per-channel interrupt status register. Software reaches all of them through a simple memory-mapped port inside a 1 KB window. The port takes 64-bit accesses, or 32-bit accesses where offset +4 selects the upper half of a register. Read data returns one cycle after the request.

The block drives the main counter value, the global enable and the legacy-route bit to the timer channels. It also drives three per-channel strobe vectors. The arm vector fires when the enable bit turns on, the disarm vector fires when it turns off, and the clear vector fires when software acknowledges a status bit. Each channel reports an interrupt event on a per-channel set input, and that event sets its status bit. One clock cycle is one counter tick.

Top module: `evt_glb_regs`

## Requirements
- R1: After reset, the counter, configuration and status registers read zero, and every strobe output and `rd_valid` are low.
- R2: The capability register at offset 0x000 has this layout. Bits 7:0 hold revision 1. Bits 12:8 hold the channel count minus one. Bit 13 is 1 for a 64-bit counter. Bit 15 is the legacy-route-capable flag (1). Bits 31:16 hold the vendor ID 0xA5C3. Bits 63:32 hold the tick period in femtoseconds (10,000,000). With 3 channels it reads 0x00989680_A5C3A201.
- R3: The configuration register at offset 0x010 accepts writes only to bit 0 (enable) and bit 1 (legacy route). All other bits read zero whatever is written.
- R4: While enable is 1, the counter at offset 0x0F0 increments once per clock. While enable is 0, it holds its value. After re-enable, it resumes from the held value.
- R5: A 0-to-1 change of enable pulses every `tmr_arm` bit for exactly one cycle. A 1-to-0 change pulses every `tmr_disarm` bit for one cycle. A write that leaves enable unchanged pulses neither vector.
- R6: A `tmr_irq_set` bit sets the matching bit of the status register at offset 0x020. Writing 1 to a status bit that is set clears it and pulses the matching `tmr_clr` bit for one cycle. Writing 0, or writing 1 to a bit that is already clear, changes nothing and pulses nothing.
- R7: Software can write the counter at any time, including while enabled. The written value appears on the next cycle, and counting continues from it.
- R8: A 32-bit access at a register's offset +4 reads or writes bits 63:32, returned or taken on data bits 31:0. A 32-bit access at +0 reaches bits 31:0. A 64-bit access reaches the whole register.
- R9: Reads of unmapped offsets, misaligned offsets (address bits 1:0 not zero) and 64-bit accesses at +4 return zero. Writes to them change no register.
- R10: `rd_valid` is high exactly one cycle after each read request. `rd_data` then holds the register value from before that request's clock edge.
- R11: When a status bit is set by `tmr_irq_set` in the same cycle that software clears it, the bit stays set and the clear strobe still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_wdata | input | 64 | Write data (bits 31:0 for 32-bit access) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| tmr_irq_set | input | NUM_TMR | Per-channel interrupt event, sets status |
| cnt_value | output | 64 | Main counter value |
| glb_enable | output | 1 | Global enable bit |
| glb_legacy | output | 1 | Legacy-route bit |
| tmr_arm | output | NUM_TMR | Per-channel re-arm strobe |
| tmr_disarm | output | NUM_TMR | Per-channel disarm strobe |
| tmr_clr | output | NUM_TMR | Per-channel status-clear strobe |

## Verification
The bench targets the counter around enable edges. A design that counts on the enable write edge itself would be off by one after every resume, and one that resets on disable would lose the held value. It writes enable twice in a row, which catches strobe logic that pulses on level instead of on edge. It writes 1 to status bits that are already clear, and raises a set in the same cycle as a clear. A wrong design would either emit spurious clear strobes or let software drop a fresh event. Half-width writes at +4 and 64-bit accesses at +4 check lane steering, where a fault would corrupt the wrong half of the counter.

// File: rtl/evt_glb_pkg.sv
package evt_glb_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CAP,
      SEL_CFG,
      SEL_STS,
      SEL_CNT
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e    sel;
      logic        hi;
      logic        wide;
      logic [63:0] mask;
      logic [63:0] data;
   } acc_t;

   localparam int unsigned OFF_CAP = 'h000;
   localparam int unsigned OFF_CFG = 'h010;
   localparam int unsigned OFF_STS = 'h020;
   localparam int unsigned OFF_CNT = 'h0F0;

   localparam logic [1:0] CFG_WMASK = 2'b11;
   localparam int         CFG_EN   = 0;
   localparam int         CFG_LEG  = 1;

   localparam logic [7:0] REV_ID = 8'h01;

endpackage

// File: rtl/evt_glb_decode.sv
module evt_glb_decode
   import evt_glb_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wide_i,
   input  logic [63:0]       wdata_i,
   output acc_t              acc_o
);

   localparam int IW = ADDR_W - 3;

   logic [IW-1:0] word_idx;
   logic          aligned;

   assign word_idx = addr_i[ADDR_W-1:3];
   assign aligned  = (addr_i[1:0] == 2'b00) && !(wide_i && addr_i[2]);

   always_comb begin
      acc_o      = '0;
      acc_o.wide = wide_i;
      acc_o.hi   = !wide_i && addr_i[2];
      acc_o.sel  = SEL_NONE;
      if (aligned) begin
         if (word_idx == IW'(OFF_CAP >> 3))      acc_o.sel = SEL_CAP;
         else if (word_idx == IW'(OFF_CFG >> 3)) acc_o.sel = SEL_CFG;
         else if (word_idx == IW'(OFF_STS >> 3)) acc_o.sel = SEL_STS;
         else if (word_idx == IW'(OFF_CNT >> 3)) acc_o.sel = SEL_CNT;
      end
      if (wide_i) begin
         acc_o.mask = '1;
         acc_o.data = wdata_i;
      end else if (addr_i[2]) begin
         acc_o.mask = {32'hFFFF_FFFF, 32'h0};
         acc_o.data = {wdata_i[31:0], 32'h0};
      end else begin
         acc_o.mask = {32'h0, 32'hFFFF_FFFF};
         acc_o.data = {32'h0, wdata_i[31:0]};
      end
   end

endmodule

// File: rtl/evt_glb_counter.sv
module evt_glb_counter #(
   parameter int CNT_W = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en_i,
   input  logic        ld_i,
   input  logic [63:0] mask_i,
   input  logic [63:0] data_i,
   output logic [63:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ld_i) begin
         cnt_q <= (cnt_q & ~mask_i[CNT_W-1:0]) | (data_i[CNT_W-1:0] & mask_i[CNT_W-1:0]);
      end else if (en_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   if (CNT_W == 64) begin : g_full
      assign cnt_o = cnt_q;
   end else begin : g_narrow
      assign cnt_o = {{(64-CNT_W){1'b0}}, cnt_q};
   end

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !ld_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !ld_i) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_glb_cfg.sv
module evt_glb_cfg
   import evt_glb_pkg::*;
#(
   parameter int NUM_TMR = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [1:0]         mask_i,
   input  logic [1:0]         data_i,
   output logic               en_o,
   output logic               leg_o,
   output logic [NUM_TMR-1:0] arm_o,
   output logic [NUM_TMR-1:0] disarm_o
);

   logic [1:0] cfg_q;
   logic [1:0] cfg_n;
   logic [1:0] wm;
   logic       rise;
   logic       fall;

   assign wm    = mask_i & CFG_WMASK;
   assign cfg_n = wr_i ? ((cfg_q & ~wm) | (data_i & wm)) : cfg_q;
   assign rise  = cfg_n[CFG_EN] & ~cfg_q[CFG_EN];
   assign fall  = ~cfg_n[CFG_EN] & cfg_q[CFG_EN];

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_n;
   end

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_strb
      logic arm_q;
      logic dis_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            arm_q <= 1'b0;
            dis_q <= 1'b0;
         end else begin
            arm_q <= rise;
            dis_q <= fall;
         end
      end
      assign arm_o[i]    = arm_q;
      assign disarm_o[i] = dis_q;
   end

   assign en_o  = cfg_q[CFG_EN];
   assign leg_o = cfg_q[CFG_LEG];

   // R5
   arm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|arm_o) |-> (en_o && !$past(en_o)));

   // R5
   disarm_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|disarm_o) |-> (!en_o && $past(en_o)));

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((|arm_o) && (|disarm_o)));

endmodule

// File: rtl/evt_glb_status.sv
module evt_glb_status #(
   parameter int NUM_TMR = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_TMR-1:0] set_i,
   input  logic               wr_i,
   input  logic [NUM_TMR-1:0] mask_i,
   input  logic [NUM_TMR-1:0] data_i,
   output logic [NUM_TMR-1:0] sts_o,
   output logic [NUM_TMR-1:0] clr_o
);

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_bit
      logic sts_q;
      logic clr_q;
      logic hit;
      assign hit = wr_i & mask_i[i] & data_i[i] & sts_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sts_q <= 1'b0;
            clr_q <= 1'b0;
         end else begin
            sts_q <= (sts_q & ~hit) | set_i[i];
            clr_q <= hit;
         end
      end
      assign sts_o[i] = sts_q;
      assign clr_o[i] = clr_q;
   end

   // R6
   clr_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_o & ~$past(sts_o)) == '0));

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/evt_glb_regs.sv
module evt_glb_regs
   import evt_glb_pkg::*;
#(
   parameter int          NUM_TMR   = 3,
   parameter int          CNT_W     = 64,
   parameter int          ADDR_W    = 10,
   parameter logic [15:0] VENDOR_ID = 16'hA5C3,
   parameter int unsigned TICK_FS   = 10_000_000,
   parameter bit          LEG_CAP   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               req_wide,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [63:0]        req_wdata,
   output logic               rd_valid,
   output logic [63:0]        rd_data,
   input  logic [NUM_TMR-1:0] tmr_irq_set,
   output logic [63:0]        cnt_value,
   output logic               glb_enable,
   output logic               glb_legacy,
   output logic [NUM_TMR-1:0] tmr_arm,
   output logic [NUM_TMR-1:0] tmr_disarm,
   output logic [NUM_TMR-1:0] tmr_clr
);

   localparam logic        CNT64    = (CNT_W == 64);
   localparam logic [63:0] CAP_WORD = {TICK_FS[31:0], VENDOR_ID, LEG_CAP, 1'b0, CNT64,
                                       5'(NUM_TMR - 1), REV_ID};

   if (NUM_TMR < 3 || NUM_TMR > 32) begin : g_bad_tmr
      $error("NUM_TMR must lie in 3..32");
   end
   if (CNT_W != 32 && CNT_W != 64) begin : g_bad_cnt
      $error("CNT_W must be 32 or 64");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   acc_t               acc;
   logic               wr_cfg;
   logic               wr_sts;
   logic               wr_cnt;
   logic               rd_req;
   logic [NUM_TMR-1:0] sts;
   logic [63:0]        full_val;
   logic [63:0]        rd_val;
   logic               rd_valid_q;
   logic [63:0]        rd_data_q;

   evt_glb_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i  (req_addr),
      .wide_i  (req_wide),
      .wdata_i (req_wdata),
      .acc_o   (acc)
   );

   assign wr_cfg = req_valid && req_write && (acc.sel == SEL_CFG);
   assign wr_sts = req_valid && req_write && (acc.sel == SEL_STS);
   assign wr_cnt = req_valid && req_write && (acc.sel == SEL_CNT);
   assign rd_req = req_valid && !req_write;

   evt_glb_cfg #(.NUM_TMR(NUM_TMR)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_cfg),
      .mask_i   (acc.mask[1:0]),
      .data_i   (acc.data[1:0]),
      .en_o     (glb_enable),
      .leg_o    (glb_legacy),
      .arm_o    (tmr_arm),
      .disarm_o (tmr_disarm)
   );

   evt_glb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (glb_enable),
      .ld_i   (wr_cnt),
      .mask_i (acc.mask),
      .data_i (acc.data),
      .cnt_o  (cnt_value)
   );

   evt_glb_status #(.NUM_TMR(NUM_TMR)) u_sts (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (tmr_irq_set),
      .wr_i   (wr_sts),
      .mask_i (acc.mask[NUM_TMR-1:0]),
      .data_i (acc.data[NUM_TMR-1:0]),
      .sts_o  (sts),
      .clr_o  (tmr_clr)
   );

   always_comb begin
      unique case (acc.sel)
         SEL_CAP: full_val = CAP_WORD;
         SEL_CFG: full_val = {62'h0, glb_legacy, glb_enable};
         SEL_STS: full_val = {{(64-NUM_TMR){1'b0}}, sts};
         SEL_CNT: full_val = cnt_value;
         default: full_val = '0;
      endcase
      if (acc.wide)    rd_val = full_val;
      else if (acc.hi) rd_val = {32'h0, full_val[63:32]};
      else             rd_val = {32'h0, full_val[31:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= rd_req;
         rd_data_q  <= rd_req ? rd_val : '0;
      end
   end

   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;

   // R10
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && acc.sel == SEL_NONE) |=> (rd_data == 64'h0));

   // R2
   cap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && acc.sel == SEL_CAP && acc.wide) |=> (rd_data == CAP_WORD));

endmodule

// File: tb/tb_evt_glb_regs.sv
module tb_evt_glb_regs;

   localparam int          NT  = 3;
   localparam int          AW  = 10;
   localparam logic [63:0] CAP = 64'h00989680_A5C3A201;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_write = 1'b0;
   logic           req_wide = 1'b0;
   logic [AW-1:0]  req_addr = '0;
   logic [63:0]    req_wdata = '0;
   logic           rd_valid;
   logic [63:0]    rd_data;
   logic [NT-1:0]  tmr_irq_set = '0;
   logic [63:0]    cnt_value;
   logic           glb_enable;
   logic           glb_legacy;
   logic [NT-1:0]  tmr_arm;
   logic [NT-1:0]  tmr_disarm;
   logic [NT-1:0]  tmr_clr;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   evt_glb_regs #(.NUM_TMR(NT)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .tmr_irq_set(tmr_irq_set),
      .cnt_value(cnt_value), .glb_enable(glb_enable), .glb_legacy(glb_legacy),
      .tmr_arm(tmr_arm), .tmr_disarm(tmr_disarm), .tmr_clr(tmr_clr)
   );

   // Reference state, updated from the requirements at each clock edge
   logic [63:0]   m_cnt;
   logic          m_en;
   logic          m_leg;
   logic [NT-1:0] m_sts;
   logic [63:0]   mm, md;
   logic [NT-1:0] mclr;
   int            ms;

   function automatic int f_sel(logic [AW-1:0] a, logic w);
      if (a[1:0] != 2'b00) return 0;
      if (w && a[2]) return 0;
      case (a[9:3])
         7'd0:  return 1;
         7'd2:  return 2;
         7'd4:  return 3;
         7'd30: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic logic [63:0] f_mask(logic [AW-1:0] a, logic w);
      if (w) return '1;
      return a[2] ? 64'hFFFF_FFFF_0000_0000 : 64'h0000_0000_FFFF_FFFF;
   endfunction

   function automatic logic [63:0] f_data(logic [AW-1:0] a, logic w, logic [63:0] d);
      if (w) return d;
      return a[2] ? {d[31:0], 32'h0} : {32'h0, d[31:0]};
   endfunction

   function automatic logic [63:0] f_read(logic [AW-1:0] a, logic w);
      logic [63:0] full;
      case (f_sel(a, w))
         1: full = CAP;
         2: full = {62'h0, m_leg, m_en};
         3: full = {61'h0, m_sts};
         4: full = m_cnt;
         default: return 64'h0;
      endcase
      if (w) return full;
      return a[2] ? {32'h0, full[63:32]} : {32'h0, full[31:0]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_en = 1'b0; m_leg = 1'b0; m_sts = '0;
      end else begin
         ms = (req_valid && req_write) ? f_sel(req_addr, req_wide) : 0;
         mm = f_mask(req_addr, req_wide);
         md = f_data(req_addr, req_wide, req_wdata);
         if (ms == 4)   m_cnt = (m_cnt & ~mm) | (md & mm);
         else if (m_en) m_cnt = m_cnt + 64'd1;
         mclr = (ms == 3) ? (md[NT-1:0] & mm[NT-1:0]) : '0;
         m_sts = (m_sts & ~mclr) | tmr_irq_set;
         if (ms == 2) begin
            if (mm[0]) m_en  = md[0];
            if (mm[1]) m_leg = md[1];
         end
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic w, logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wide = w; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [AW-1:0] a, logic w);
      logic [63:0] exp;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wide = w;
      exp = f_read(a, w);
      @(negedge clk);
      req_valid = 1'b0;
      chk({req, " rd_valid"}, {63'h0, rd_valid}, 64'h1);
      chk(req, rd_data, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] c0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cnt", cnt_value, 64'h0);
      chk("R1 cfg", {62'h0, glb_legacy, glb_enable}, 64'h0);
      chk("R1 strobes", {55'h0, tmr_arm, tmr_disarm, tmr_clr}, 64'h0);
      chk("R1 rd_valid", {63'h0, rd_valid}, 64'h0);
      rd_chk("R1 status", 10'h020, 1'b1);

      // R2 capability, R8 halves
      rd_chk("R2 cap", 10'h000, 1'b1);
      chk("R2 cap literal", f_read(10'h000, 1'b1), CAP);
      rd_chk("R8 cap low", 10'h000, 1'b0);
      rd_chk("R8 cap high", 10'h004, 1'b0);

      // R3 only two bits writable
      wr(10'h010, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
      rd_chk("R3 cfg mask", 10'h010, 1'b1);
      chk("R3 legacy", {63'h0, glb_legacy}, 64'h1);

      // R5 rising enable
      wr(10'h010, 1'b1, 64'h1);
      chk("R5 arm", {61'h0, tmr_arm}, 64'h7);
      chk("R5 no disarm", {61'h0, tmr_disarm}, 64'h0);
      c0 = cnt_value;
      @(negedge clk);
      chk("R5 arm one cycle", {61'h0, tmr_arm}, 64'h0);
      chk("R4 step", cnt_value, c0 + 64'd1);
      repeat (20) @(negedge clk);
      chk("R4 run", cnt_value, m_cnt);
      chk("R4 run value", cnt_value, c0 + 64'd21);

      // R5 falling, R4 hold
      wr(10'h010, 1'b1, 64'h0);
      chk("R5 disarm", {61'h0, tmr_disarm}, 64'h7);
      c0 = cnt_value;
      repeat (10) @(negedge clk);
      chk("R4 hold", cnt_value, c0);
      wr(10'h010, 1'b1, 64'h1);
      chk("R4 resume held", cnt_value, c0);
      @(negedge clk);
      chk("R4 resume step", cnt_value, c0 + 64'd1);
      wr(10'h010, 1'b1, 64'h1);
      chk("R5 no arm when unchanged", {58'h0, tmr_arm, tmr_disarm}, 64'h0);

      // R7 write while enabled
      wr(10'h0F0, 1'b1, 64'h1234_5678_9ABC_DEF0);
      chk("R7 load", cnt_value, 64'h1234_5678_9ABC_DEF0);
      @(negedge clk);
      chk("R7 continue", cnt_value, 64'h1234_5678_9ABC_DEF1);

      // R8 upper half write
      wr(10'h010, 1'b1, 64'h0);
      wr(10'h0F4, 1'b0, 64'h0000_0000_CAFE_0001);
      chk("R8 upper half", cnt_value[63:32], 64'hCAFE_0001);
      chk("R8 lower kept", cnt_value[31:0], {32'h0, m_cnt[31:0]});
      rd_chk("R8 cnt wide", 10'h0F0, 1'b1);
      rd_chk("R8 cnt hi", 10'h0F4, 1'b0);

      // R6 status
      @(negedge clk) tmr_irq_set = 3'b101;
      @(negedge clk) tmr_irq_set = 3'b000;
      rd_chk("R6 set", 10'h020, 1'b1);
      wr(10'h020, 1'b1, 64'h0);
      chk("R6 write0 no strobe", {61'h0, tmr_clr}, 64'h0);
      wr(10'h020, 1'b1, 64'h2);
      chk("R6 clear-bit no strobe", {61'h0, tmr_clr}, 64'h0);
      rd_chk("R6 unchanged", 10'h020, 1'b1);
      wr(10'h020, 1'b0, 64'h1);
      chk("R6 clr strobe", {61'h0, tmr_clr}, 64'h1);
      rd_chk("R6 cleared", 10'h020, 1'b0);

      // R11 simultaneous set and clear
      @(negedge clk);
      tmr_irq_set = 3'b100;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h020; req_wide = 1'b1; req_wdata = 64'h4;
      @(negedge clk);
      tmr_irq_set = '0; req_valid = 1'b0; req_write = 1'b0;
      chk("R11 strobe", {61'h0, tmr_clr}, 64'h4);
      rd_chk("R11 stays set", 10'h020, 1'b1);

      // R9 unmapped
      rd_chk("R9 unmapped", 10'h018, 1'b1);
      rd_chk("R9 top", 10'h3FC, 1'b0);
      rd_chk("R9 misaligned", 10'h011, 1'b0);
      rd_chk("R9 wide at +4", 10'h0F4, 1'b1);
      c0 = cnt_value;
      wr(10'h018, 1'b1, '1);
      wr(10'h0F2, 1'b0, '1);
      wr(10'h0F4, 1'b1, '1);
      wr(10'h011, 1'b0, '1);
      chk("R9 cnt untouched", cnt_value, c0);
      chk("R9 cfg untouched", {62'h0, glb_legacy, glb_enable}, 64'h0);

      // Random mix
      for (int i = 0; i < 400; i++) begin
         int op;
         logic [AW-1:0] a;
         logic w;
         op = $urandom_range(0, 4);
         case ($urandom_range(0, 9))
            0: a = 10'h000; 1: a = 10'h004; 2: a = 10'h010; 3: a = 10'h014;
            4: a = 10'h020; 5: a = 10'h024; 6: a = 10'h0F0; 7: a = 10'h0F4;
            8: a = 10'h030; default: a = 10'h3F8;
         endcase
         w = 1'($urandom_range(0, 1));
         case (op)
            0: rd_chk("R10 random read", a, w);
            1: wr(10'h010, 1'b1, {62'h0, 2'($urandom_range(0, 3))});
            2: wr(a[2] ? 10'h0F4 : 10'h0F0, w, {$urandom, $urandom});
            3: begin
               @(negedge clk) tmr_irq_set = NT'($urandom_range(0, 7));
               @(negedge clk) tmr_irq_set = '0;
            end
            default: wr(10'h020, 1'b1, {61'h0, 3'($urandom_range(0, 7))});
         endcase
         chk("R4 random cnt", cnt_value, m_cnt);
      end

      @(negedge clk);
      chk("R10 idle", {63'h0, rd_valid}, 64'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule